// File: doc/BRIEF.md
# Compare-Match Interval Timer

The block produces periodic interrupt requests from a 16-bit up-counter. A prescaler divides the system clock into a single-cycle tick. Each tick advances the counter by one. When a tick finds the counter equal to the programmed reference value, four things happen in the same clock edge: the counter restarts from zero, a sticky request flag is set, an output latch flips, and the interrupt line rises if interrupts are enabled. One period is therefore (reference + 1) ticks, and the latch output is a square wave of twice that period.

Software drives the block through a plain register port. One write selector loads the 8-bit mode register, one loads the 16-bit reference, and one loads the enable and request flags. A combinational read port returns the mode, the reference, the flags or the live count. Writing the mode register with its start bit set restarts the whole timing chain. Clearing the count-enable bit freezes the counter, and the frozen value can still be read. The block carries no data stream, so it has no valid/ready handshake. A write takes effect on the clock edge where `wr_en` is high, and a read is valid in the same cycle.

Top module: `intv_timer`

## Requirements
- R1: A synchronous active-high reset clears the mode register, the reference, the count, both flags, the output latch and the prescaler, so every readback value and both outputs are 0.
- R2: The count advances by one on each prescaled tick. It advances only while mode bit 7 (run), bit 6 (clock gate) and bit 2 (count enable) are all 1. If bit 6 or bit 7 is 0, the count stays at 0 after a start.
- R3: Mode bits 5:4 set the tick period. 11 gives 16 cycles, 10 gives 64, 01 gives 256 and 00 gives 1024. After a start, the first tick moves the count one full period after the start edge.
- R4: When a tick finds count equal to the reference, the count becomes 0, the request flag becomes 1 and the output latch `tog_out` inverts, all on that edge.
- R5: A reference of 0 gives a match on every tick, so `tog_out` inverts once per tick period.
- R6: While mode bit 2 is 0, the count and `tog_out` hold their values, and the count stays readable.
- R7: A mode write with bit 3 = 1 clears the count, the request flag, the latch and the prescaler for one cycle. Counting then restarts. Bit 3 always reads back as 0, and the other written mode bits are stored.
- R8: `irq` is high exactly when the request flag and the enable flag are both 1.
- R9: A flag write stores data bit 0 as enable and data bit 1 as request, so writing 0 clears the request. If a match falls on the same edge as such a write, the request is 1 afterwards.
- R10: Write selectors: 0 = mode (data bits 7:0), 1 = reference, 2 = flags, 3 = no effect. Read selectors: 0 = mode, 1 = reference, 2 = {request, enable} in bits 1:0, 3 = count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target selector |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read source selector |
| rd_data | output | 16 | Read data, combinational |
| irq | output | 1 | Interrupt request, qualified by enable |
| tog_out | output | 1 | Output latch, inverted on every match |

## Verification
Two pairs of events can land on the same edge: the counter's match, and a software write that clears the request flag. The bench counts ticks from a start edge, so it knows the exact edge of the third tick. It schedules the flag write for that edge and expects the request flag to read 1 afterwards, while the latch flips and the count wraps. A second pass does the same clear with no match nearby, to show that the write alone lowers the flag. The start write and a pending tick are also made to meet, and the bench then expects a zero count and a full period before the next advance.

// File: rtl/intv_pkg.sv
package intv_pkg;
  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_REF  = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_CNT  = 2'd3
  } sel_e;

  localparam int MB_RUN   = 7;
  localparam int MB_CLKON = 6;
  localparam int MB_DIVHI = 5;
  localparam int MB_DIVLO = 4;
  localparam int MB_START = 3;
  localparam int MB_CNTEN = 2;

  localparam int FB_EN  = 0;
  localparam int FB_REQ = 1;
endpackage

// File: rtl/intv_prescaler.sv
module intv_prescaler #(
  parameter int PRE_W = 10,
  parameter int STEP  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       pulse
);
  localparam int NSEL = 4;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask [NSEL];

  // selector g keeps PRE_W - STEP*g low bits: larger code, shorter period
  for (genvar g = 0; g < NSEL; g++) begin : g_mask
    assign mask[g] = {PRE_W{1'b1}} >> (STEP * g);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) pre <= '0;
    else if (run)   pre <= pre + 1'b1;
  end

  assign pulse = run && ((pre & mask[sel]) == mask[sel]);

  // R3
  pulse_gap_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/intv_counter.sv
module intv_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] ref_val,
  output logic [W-1:0] count,
  output logic         hit,
  output logic         tog
);
  assign hit = tick && !clr && (count == ref_val);

  always_ff @(posedge clk) begin
    if (rst || clr)  count <= '0;
    else if (hit)    count <= '0;
    else if (tick)   count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) tog <= 1'b0;
    else if (hit)   tog <= ~tog;
  end

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(count));

  // R4
  match_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && count == ref_val) |=> (count == '0));

  // R4
  tog_flip_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (tog != $past(tog)));
endmodule

// File: rtl/intv_regs.sv
module intv_regs
  import intv_pkg::*;
#(
  parameter int W      = 16,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [W-1:0]      wr_data,
  input  logic              hit,
  output logic [MODE_W-1:0] mode,
  output logic [W-1:0]      ref_val,
  output logic              ie,
  output logic              req,
  output logic              start
);
  localparam logic [MODE_W-1:0] KEEP = ~(MODE_W'(1) << MB_START);

  logic wr_mode, wr_ref, wr_flag;

  assign wr_mode = wr_en && (wr_sel == SEL_MODE);
  assign wr_ref  = wr_en && (wr_sel == SEL_REF);
  assign wr_flag = wr_en && (wr_sel == SEL_FLAG);
  assign start   = wr_mode && wr_data[MB_START];

  always_ff @(posedge clk) begin
    if (rst)          mode <= '0;
    else if (wr_mode) mode <= wr_data[MODE_W-1:0] & KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst)         ref_val <= '0;
    else if (wr_ref) ref_val <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)          ie <= 1'b0;
    else if (wr_flag) ie <= wr_data[FB_EN];
  end

  // priority: reset/start clear, then match, then software write
  always_ff @(posedge clk) begin
    if (rst || start) req <= 1'b0;
    else if (hit)     req <= 1'b1;
    else if (wr_flag) req <= wr_data[FB_REQ];
  end

  // R9
  req_set_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> req);

  // R7
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    wr_mode |=> !mode[MB_START]);
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_pkg::*;
#(
  parameter int W      = 16,
  parameter int MODE_W = 8,
  parameter int PRE_W  = 10,
  parameter int STEP   = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         irq,
  output logic         tog_out
);
  logic [MODE_W-1:0] mode;
  logic [W-1:0]      ref_val;
  logic [W-1:0]      count;
  logic              ie, req, start, pulse, tick, hit;

  intv_regs #(.W(W), .MODE_W(MODE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hit(hit), .mode(mode), .ref_val(ref_val), .ie(ie), .req(req),
    .start(start)
  );

  intv_prescaler #(.PRE_W(PRE_W), .STEP(STEP)) u_pre (
    .clk(clk), .rst(rst), .clr(start), .run(mode[MB_CLKON]),
    .sel(mode[MB_DIVHI:MB_DIVLO]), .pulse(pulse)
  );

  assign tick = pulse && mode[MB_RUN] && mode[MB_CNTEN];

  intv_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .clr(start), .tick(tick), .ref_val(ref_val),
    .count(count), .hit(hit), .tog(tog_out)
  );

  assign irq = req && ie;

  always_comb begin
    case (rd_sel)
      SEL_MODE: rd_data = {{(W-MODE_W){1'b0}}, mode};
      SEL_REF:  rd_data = ref_val;
      SEL_FLAG: rd_data = {{(W-2){1'b0}}, req, ie};
      default:  rd_data = count;
    endcase
  end

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (count == '0 && !tog_out && !irq));

  // R2
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !(mode[MB_RUN] && mode[MB_CNTEN])) |=> $stable(count));
endmodule

// File: tb/intv_timer_bench.sv
module intv_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        irq, tog_out;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  intv_timer u_intv_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .tog_out(tog_out)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; the write lands on the next rising edge
  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    rd_sel = s;
    #1 v = rd_data;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v); check("R1 readback after reset", v, 16'h0);
    end
    check("R1 irq after reset", 16'(irq), 16'h0);
    check("R1 tog_out after reset", 16'(tog_out), 16'h0);
  endtask

  task automatic t_match;
    logic [15:0] v;
    wr(2'd1, 16'd2);
    wr(2'd2, 16'h0001);
    rd(2'd1, v); check("R10 reference readback", v, 16'd2);
    wr(2'd0, 16'h00FC);
    rd(2'd0, v); check("R7 start bit reads 0", v, 16'h00F4);
    wait_n(15); rd(2'd3, v); check("R3 no tick before 16 cycles", v, 16'd0);
    wait_n(1);  rd(2'd3, v); check("R2 first tick", v, 16'd1);
    wait_n(16); rd(2'd3, v); check("R2 second tick", v, 16'd2);
    check("R4 no toggle before match", 16'(tog_out), 16'h0);
    wait_n(16); rd(2'd3, v); check("R4 count wraps on match", v, 16'd0);
    rd(2'd2, v); check("R4 request flag set", v, 16'h0003);
    check("R4 tog_out inverted", 16'(tog_out), 16'h1);
    check("R8 irq with enable", 16'(irq), 16'h1);
  endtask

  task automatic t_irq_gate;
    logic [15:0] v;
    wr(2'd2, 16'h0002);
    check("R8 irq off when disabled", 16'(irq), 16'h0);
    rd(2'd2, v); check("R9 request kept with enable 0", v, 16'h0002);
    wr(2'd2, 16'h0003);
    check("R8 irq on when enabled", 16'(irq), 16'h1);
    wr(2'd2, 16'h0001);
    rd(2'd2, v); check("R9 software clear", v, 16'h0001);
    check("R8 irq off after clear", 16'(irq), 16'h0);
    wr(2'd3, 16'hFFFF);
    rd(2'd1, v); check("R10 selector 3 write ignored", v, 16'd2);
  endtask

  task automatic t_freeze;
    logic [15:0] a, b;
    logic t0;
    wr(2'd0, 16'h00F0);
    rd(2'd3, a); t0 = tog_out;
    wait_n(100);
    rd(2'd3, b); check("R6 count frozen", b, a);
    check("R6 tog_out frozen", 16'(tog_out), 16'(t0));
  endtask

  task automatic t_start;
    logic [15:0] v;
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h00FC);
    wait_n(64);
    rd(2'd3, v); check("R7 setup count", v, 16'd1);
    check("R7 setup tog", 16'(tog_out), 16'h1);
    wait_n(15);
    wr(2'd0, 16'h00FC);
    rd(2'd3, v); check("R7 start clears count", v, 16'd0);
    rd(2'd2, v); check("R7 start clears request", v, 16'h0001);
    check("R7 start clears tog_out", 16'(tog_out), 16'h0);
    wait_n(15); rd(2'd3, v); check("R7 prescaler restarted", v, 16'd0);
    wait_n(1);  rd(2'd3, v); check("R7 counting resumes", v, 16'd1);
  endtask

  task automatic t_ref_zero;
    logic [15:0] v;
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h00FC);
    wait_n(16);
    check("R5 first tick toggles", 16'(tog_out), 16'h1);
    rd(2'd3, v); check("R5 count stays 0", v, 16'd0);
    wait_n(16);
    check("R5 second tick toggles", 16'(tog_out), 16'h0);
  endtask

  task automatic t_race;
    logic [15:0] v;
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h00FC);
    wait_n(47);
    wr(2'd2, 16'h0001);
    rd(2'd2, v); check("R9 match beats clear", v, 16'h0003);
    check("R9 tog flips on race edge", 16'(tog_out), 16'h1);
    wr(2'd2, 16'h0001);
    rd(2'd2, v); check("R9 later clear works", v, 16'h0001);
  endtask

  task automatic t_div(input logic [15:0] m, input int per, input string tag);
    logic [15:0] v;
    wr(2'd1, 16'd5);
    wr(2'd0, m);
    wait_n(per - 1); rd(2'd3, v); check(tag, v, 16'd0);
    wait_n(1);       rd(2'd3, v); check(tag, v, 16'd1);
  endtask

  task automatic t_gates;
    logic [15:0] v;
    wr(2'd0, 16'h00BC);
    wait_n(64); rd(2'd3, v); check("R2 clock gate off", v, 16'd0);
    wr(2'd0, 16'h007C);
    wait_n(64); rd(2'd3, v); check("R2 run bit off", v, 16'd0);
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    t_reset();
    t_match();
    t_irq_gate();
    t_freeze();
    t_start();
    t_ref_zero();
    t_race();
    t_div(16'h00CC, 1024, "R3 divide 1024");
    t_div(16'h00DC, 256,  "R3 divide 256");
    t_div(16'h00EC, 64,   "R3 divide 64");
    t_gates();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #2000000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule